// File: doc/BRIEF.md
# Byte-Wide General-Purpose I/O Port

This block is one parameterised general-purpose I/O port. Three byte-wide registers sit behind a small synchronous register bus: a data register that holds what the port drives, a direction register that picks input or output for each pin, and a read-only view of the pin levels. For every pin the block produces an output enable, an output value and a weak-pullup enable for the pad cell. It takes the pad's input level back through a two-stage synchronizer.

A parameter picks the flavour. The plain flavour leaves an input pin tri-stated. The pullup-capable flavour reuses the data bit of an input pin as that pin's weak-pullup request, and it brings the data register out of reset with every bit set. Software sets the pin directions, writes data, and reads the pins back at any time, whatever the directions are.

Top module: `gpio_port`

## Requirements
- R1: Reset is synchronous and active-low. After reset the direction register reads 0x00 and every output enable is 0. The data register reads 0x00 in the plain flavour and 0xFF in the pullup-capable flavour.
- R2: A write to the direction register leaves the stored data register contents and the `pad_out` bus unchanged.
- R3: `pad_oe[i]` equals direction bit i. `pad_out` always mirrors the full data register, so an output pin drives its data bit.
- R4: `pad_pu[i]` is 1 only in the pullup-capable flavour, for a pin whose direction bit is 0 and whose data bit is 1. It is 0 for every output pin and always 0 in the plain flavour.
- R5: A read of address 1 (input register) returns the pad levels, whether each pin is set as input or output.
- R6: Writes to address 1 are ignored. The value read there and both writable registers stay unchanged.
- R7: Address 0 is the data register, address 2 is the direction register, and address 3 is unmapped. A read of address 3 returns 0x00, and a write to it changes nothing.
- R8: A pad change made between clock edges k-1 and k becomes visible in the input register after edge k+1. Between edges k and k+1 the old value is still read.
- R9: The data and direction registers read back the last full byte written. A write takes effect on the clock edge on which the write enable is high, and read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register select (0 data, 1 input, 2 direction) |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the selected register |
| pad_in | input | WIDTH | Level sensed at each pad |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin drive value |
| pad_pu | output | WIDTH | Per-pin weak-pullup enable |

## Verification
The bench builds two copies side by side with WIDTH=8 and the default two synchronizer stages: `u_dut` with the pullup flavour switched on and `u_dut_plain` with it off. Both flavours therefore run the same bus traffic, which shows the difference in data register reset values and the pullup gating. The pads are modelled as wires that merge the port's own drive, an external driver and the pullup. This makes the pin readback under mixed directions and the exact two-edge synchronizer latency observable at the bus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // Register map of the port
   localparam int unsigned GP_ADDR_DATA = 0;
   localparam int unsigned GP_ADDR_PINS = 1;
   localparam int unsigned GP_ADDR_DIR  = 2;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_PINS = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_NONE = 2'd3
   } gp_sel_e;

   function automatic gp_sel_e gp_decode(input int unsigned addr);
      case (addr)
         GP_ADDR_DATA: return SEL_DATA;
         GP_ADDR_PINS: return SEL_PINS;
         GP_ADDR_DIR:  return SEL_DIR;
         default:      return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          PULLUP_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gpio_pkg::gp_sel_e sel,
   input  logic              we,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  dir_q
);
   import gpio_pkg::*;

   localparam logic [WIDTH-1:0] DATA_RST = PULLUP_EN ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
   localparam logic [WIDTH-1:0] DIR_RST  = '0;

   logic wr_data, wr_dir;
   assign wr_data = we && (sel == SEL_DATA);
   assign wr_dir  = we && (sel == SEL_DIR);

   always_ff @(posedge clk) begin
      if (!rst_n)       data_q <= DATA_RST;
      else if (wr_data) data_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      dir_q <= DIR_RST;
      else if (wr_dir) dir_q <= wdata;
   end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          PULLUP_EN = 1'b0
) (
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_oe[i]  = dir_q[i];
      assign pad_out[i] = data_q[i];
      if (PULLUP_EN) begin : g_pullup
         assign pad_pu[i] = !dir_q[i] && data_q[i];
      end else begin : g_plain
         assign pad_pu[i] = 1'b0;
      end
   end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux #(
   parameter int unsigned WIDTH = 8
) (
   input  gpio_pkg::gp_sel_e sel,
   input  logic [WIDTH-1:0]  data_q,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic [WIDTH-1:0]  pins_q,
   output logic [WIDTH-1:0]  rdata
);
   import gpio_pkg::*;

   always_comb begin
      case (sel)
         SEL_DATA: rdata = data_q;
         SEL_PINS: rdata = pins_q;
         SEL_DIR:  rdata = dir_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PULLUP_EN   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_pu
);
   import gpio_pkg::*;

   if (WIDTH < 1)       begin : g_bad_width  $error("WIDTH must be at least 1");      end
   if (ADDR_W < 2)      begin : g_bad_addr   $error("ADDR_W must cover three registers"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync   $error("SYNC_STAGES must be at least 2"); end

   gp_sel_e          sel;
   logic [WIDTH-1:0] data_q, dir_q, pins_q;

   assign sel = gp_decode(int'(bus_addr));

   gpio_regfile #(.WIDTH(WIDTH), .PULLUP_EN(PULLUP_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(sel), .we(bus_we), .wdata(bus_wdata),
      .data_q(data_q), .dir_q(dir_q)
   );

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pins_q)
   );

   gpio_pad_ctrl #(.WIDTH(WIDTH), .PULLUP_EN(PULLUP_EN)) u_pads (
      .data_q(data_q), .dir_q(dir_q),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   gpio_rd_mux #(.WIDTH(WIDTH)) u_rd (
      .sel(sel), .data_q(data_q), .dir_q(dir_q), .pins_q(pins_q), .rdata(bus_rdata)
   );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PULLUP_EN   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pad_in,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_pu
);
   localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_NONE = ADDR_W'(3);

   logic [1:0] up_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)              up_cnt <= '0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (pad_oe == '0));

   p_dir_keeps_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DIR) |=> $stable(pad_out));

   p_dir_drives_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));

   p_no_pu_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

   if (!PULLUP_EN) begin : g_plain_chk
      p_plain_no_pu_r4: assert property (@(posedge clk) disable iff (!rst_n)
         pad_pu == '0);
   end

   p_pins_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_PINS) |=> ($stable(pad_out) && $stable(pad_oe)));

   p_unmapped_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_NONE) |-> (bus_rdata == '0));

   if (SYNC_STAGES == 2) begin : g_lat_chk
      p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (up_cnt == 2'd3 && bus_addr == A_PINS) |-> (bus_rdata == $past(pad_in, 2)));
   end

endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .PULLUP_EN(PULLUP_EN)
) u_chk (.*);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       we_plain = 1'b0, we_pu = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] ext_en = '0, ext_val = '0;

   logic [7:0] rd_plain, oe_plain, out_plain, pu_plain, line_plain;
   logic [7:0] rd_pu, oe_pu, out_pu, pu_pu, line_pu;

   always #(CLK_PERIOD/2) clk = ~clk;

   // pad wires: own drive, else external driver, else pullup, else low
   assign line_plain = (oe_plain & out_plain) | (~oe_plain & ext_en & ext_val)
                     | (~oe_plain & ~ext_en & pu_plain);
   assign line_pu    = (oe_pu & out_pu) | (~oe_pu & ext_en & ext_val)
                     | (~oe_pu & ~ext_en & pu_pu);

   gpio_port #(.WIDTH(8), .PULLUP_EN(1'b0)) u_dut_plain (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we_plain), .bus_wdata(wdata),
      .bus_rdata(rd_plain), .pad_in(line_plain), .pad_oe(oe_plain),
      .pad_out(out_plain), .pad_pu(pu_plain)
   );

   gpio_port #(.WIDTH(8), .PULLUP_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we_pu), .bus_wdata(wdata),
      .bus_rdata(rd_pu), .pad_in(line_pu), .pad_oe(oe_pu),
      .pad_out(out_pu), .pad_pu(pu_pu)
   );

   // scoreboard: field 0 rdata, 1 oe, 2 out, 3 pu; dut 0 plain, 1 pullup
   int         q_dut[$];
   int         q_fld[$];
   logic [7:0] q_exp[$];
   string      q_req[$];
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   function automatic logic [7:0] observe(int d, int f);
      case (f)
         0: return d ? rd_pu  : rd_plain;
         1: return d ? oe_pu  : oe_plain;
         2: return d ? out_pu : out_plain;
         default: return d ? pu_pu : pu_plain;
      endcase
   endfunction

   always @(negedge clk) begin
      while (q_exp.size() > 0) begin
         int d, f;
         logic [7:0] e, a;
         string r;
         d = q_dut.pop_front(); f = q_fld.pop_front();
         e = q_exp.pop_front(); r = q_req.pop_front();
         a = observe(d, f);
         checks++;
         if (a !== e) begin
            failures++;
            $display("FAIL %s dut=%0d field=%0d actual=%02h expected=%02h", r, d, f, a, e);
         end
      end
   end

   task automatic expect_field(int d, int f, logic [7:0] e, string r);
      @(posedge clk); #1;
      q_dut.push_back(d); q_fld.push_back(f); q_exp.push_back(e); q_req.push_back(r);
   endtask

   task automatic rd(int d, logic [1:0] a, logic [7:0] e, string r);
      @(posedge clk); #1;
      addr = a;
      q_dut.push_back(d); q_fld.push_back(0); q_exp.push_back(e); q_req.push_back(r);
   endtask

   task automatic wr(int d, logic [1:0] a, logic [7:0] v);
      @(posedge clk); #1;
      addr = a; wdata = v;
      if (d == 1) we_pu = 1'b1; else we_plain = 1'b1;
      @(posedge clk); #1;
      we_pu = 1'b0; we_plain = 1'b0;
   endtask

   task automatic set_ext(logic [7:0] en, logic [7:0] v);
      @(posedge clk); #1;
      ext_en = en; ext_val = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state of both flavours
      rd(0, 2'd0, 8'h00, "R1 plain data reset");
      rd(1, 2'd0, 8'hFF, "R1 pullup data reset");
      rd(0, 2'd2, 8'h00, "R1 plain dir reset");
      rd(1, 2'd2, 8'h00, "R1 pullup dir reset");
      expect_field(0, 1, 8'h00, "R1 plain oe reset");
      expect_field(1, 1, 8'h00, "R1 pullup oe reset");
      expect_field(1, 3, 8'hFF, "R4 pullup enables after reset");
      expect_field(0, 3, 8'h00, "R4 plain never pulls up");
      rd(1, 2'd1, 8'hFF, "R5 pulled-up pins read high");
      rd(0, 2'd1, 8'h00, "R5 floating plain pins read low");

      // plain flavour: data, direction, readback
      wr(0, 2'd0, 8'hA5);
      wr(0, 2'd2, 8'h3C);
      rd(0, 2'd0, 8'hA5, "R2 data kept after dir write");
      rd(0, 2'd2, 8'h3C, "R9 dir readback");
      expect_field(0, 1, 8'h3C, "R3 oe follows dir");
      expect_field(0, 2, 8'hA5, "R3 pad_out mirrors data");
      expect_field(0, 3, 8'h00, "R4 plain pullups stay off");
      idle(2);
      rd(0, 2'd1, 8'h24, "R5 pins read with mixed directions");

      // R6 writes to the input register
      wr(0, 2'd1, 8'hFF);
      rd(0, 2'd1, 8'h24, "R6 input register unchanged");
      rd(0, 2'd0, 8'hA5, "R6 data unchanged");
      rd(0, 2'd2, 8'h3C, "R6 dir unchanged");

      // R7 unmapped address
      wr(0, 2'd3, 8'h5A);
      rd(0, 2'd3, 8'h00, "R7 unmapped reads zero");
      rd(0, 2'd0, 8'hA5, "R7 data unchanged");
      rd(0, 2'd2, 8'h3C, "R7 dir unchanged");

      // pullup flavour
      wr(1, 2'd2, 8'h0F);
      wr(1, 2'd0, 8'h36);
      rd(1, 2'd0, 8'h36, "R9 data readback");
      expect_field(1, 3, 8'h30, "R4 pullup on input pins with data 1");
      expect_field(1, 1, 8'h0F, "R3 pullup oe follows dir");
      set_ext(8'hC0, 8'h40);
      idle(3);
      rd(1, 2'd1, 8'h76, "R5 pullup pins with external driver");
      rd(0, 2'd1, 8'h64, "R5 plain pins with external driver");

      // R8 synchronizer latency
      set_ext(8'hC0, 8'h00);
      rd(1, 2'd1, 8'h76, "R8 old value one edge later");
      rd(1, 2'd1, 8'h36, "R8 new value two edges later");

      // all outputs: pullups drop, data survives
      wr(1, 2'd2, 8'hFF);
      expect_field(1, 3, 8'h00, "R4 no pullup on output pins");
      expect_field(1, 2, 8'h36, "R2 pad_out kept over dir write");
      rd(1, 2'd0, 8'h36, "R2 data kept in pullup flavour");
      rd(1, 2'd2, 8'hFF, "R9 dir full byte");

      idle(2);
      finish_run();
   end
endmodule